// File: doc/BRIEF.md
# DDS Phase Accumulator Waveform Addresser

This block is the core of a direct digital synthesis source. A 48-bit phase accumulator adds a 48-bit phase increment on every accepted sample, and its top 13 bits form the address into an external waveform store. The store holds four tables of 8192 entries each (sine, ramp, sawtooth and noise), and a 2-bit table select chooses among them. The output frequency is the increment times the clock rate divided by 2^48. With the nominal 10 MHz clock, the frequency resolution is a small fraction of a microhertz.

Software programs the increment one byte at a time over a simple register write port. The first five bytes go to a shadow register. Writing the sixth byte moves all 48 bits into the live increment in one step, so the accumulator never adds a value that is only partly written. A control byte at a separate address carries the table select in its two upper bits.

The 12-bit table word is captured into an output register that feeds a DAC. Codes are offset binary: 0x000 is one extreme, 0xFFF is the other, and 0x7FF/0x800 sit on either side of mid-scale. The block passes codes through unchanged. The sample leaves on a valid/ready stream. The output register accepts a new sample whenever it is empty or its current sample is being taken. While `smp_valid` is high and `smp_ready` is low, the sample holds and the phase accumulator stops. No phase is lost under back-pressure: the output is simply delayed. `smp_valid`, once raised, stays high until reset.

Top module: `dds_wave_addr`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator to zero, selects table 0 and drops `smp_valid`. After that edge, `tbl_addr` reads 0 and `tbl_sel` reads 0.
- R2: `tbl_addr` always equals accumulator bits [47:35]. `tbl_sel` always equals the last table select written.
- R3: On every edge where the output register accepts a sample, the accumulator becomes (accumulator + live increment) modulo 2^48, with no saturation.
- R4: Register addresses 0 to 4 write increment bytes 0 to 4 (bits [7:0] up to [39:32]) into a shadow register only. These writes leave the live increment, and therefore the addressing step, unchanged.
- R5: A write to register address 5 loads increment bits [47:40] from the written byte and moves the whole 48-bit value (shadow bytes 0 to 4 plus this byte) into the live increment at that edge. The accumulator adds the new increment from the next accepted edge onward.
- R6: A write to register address 6 sets the table select from data bits [7:6]; data bits [5:0] are ignored. A write to address 7 changes nothing.
- R7: On an accepting edge the output register captures `tbl_data`, which is the table entry at the accumulator value before that edge's addition. `smp_valid` rises on the first edge after reset even when `smp_ready` is low.
- R8: While `smp_valid` is high and `smp_ready` is low, `smp_data`, `smp_valid` and the accumulator (hence `tbl_addr`) hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, nominally 10 MHz |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0-5 increment bytes (LSB first), 6 control |
| wr_data | input | 8 | Register write data |
| tbl_addr | output | 13 | Waveform table entry address (accumulator [47:35]) |
| tbl_sel | output | 2 | Waveform table select |
| tbl_data | input | 12 | Waveform word returned for `tbl_sel`/`tbl_addr`, same cycle |
| smp_valid | output | 1 | Output sample valid |
| smp_ready | input | 1 | Downstream accepts the sample |
| smp_data | output | 12 | Registered offset-binary sample |

## Verification
The bench goes after modulo-2^48 wrap with increments of 2^47 and all ones. A design that saturated, or dropped the carry into bit 47, would park or misstep the table address there. Increment bytes are written one at a time while the accumulator runs, and the bench checks that the step changes only after the sixth byte; a design that updated the live increment per byte would show a wrong step halfway through. Stalls are held for several cycles to catch a phase that keeps running, or a sample that changes while `smp_ready` is low. Control writes with the low bits set, and writes to the unused address, expose a select decoded from the wrong bits.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int DFLT_PHASE_W  = 48;
  localparam int DFLT_ADDR_W   = 13;
  localparam int DFLT_SAMPLE_W = 12;
  localparam int DFLT_SEL_W    = 2;
  localparam int BYTE_W        = 8;
endpackage

// File: rtl/dds_incr_regs.sv
module dds_incr_regs
  import dds_pkg::*;
#(
  parameter int PHASE_W = DFLT_PHASE_W,
  parameter int SEL_W   = DFLT_SEL_W,
  parameter int AW      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [BYTE_W-1:0]  wr_data,
  output logic [PHASE_W-1:0] live_inc,
  output logic [SEL_W-1:0]   tbl_sel
);
  localparam int NB = PHASE_W / BYTE_W;
  localparam logic [AW-1:0] LAST_A = AW'(NB - 1);
  localparam logic [AW-1:0] CTRL_A = AW'(NB);

  logic [PHASE_W-BYTE_W-1:0] shadow;

  // Lower increment bytes land in the shadow only
  for (genvar g = 0; g < NB - 1; g++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst) shadow[g*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && wr_addr == AW'(g)) shadow[g*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  // Final byte commits the whole increment at once
  always_ff @(posedge clk) begin
    if (rst) live_inc <= '0;
    else if (wr_en && wr_addr == LAST_A) live_inc <= {wr_data, shadow};
  end

  always_ff @(posedge clk) begin
    if (rst) tbl_sel <= '0;
    else if (wr_en && wr_addr == CTRL_A) tbl_sel <= wr_data[BYTE_W-1 -: SEL_W];
  end

  a_r4_partial_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr < LAST_A) |=> $stable(live_inc));
  a_r5_commit_top: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == LAST_A) |=> live_inc[PHASE_W-1 -: BYTE_W] == $past(wr_data));
  a_r6_sel_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CTRL_A) |=> tbl_sel == $past(wr_data[BYTE_W-1 -: SEL_W]));
  a_r6_sel_keep: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == CTRL_A) |=> $stable(tbl_sel));
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
  import dds_pkg::*;
#(
  parameter int PHASE_W = DFLT_PHASE_W,
  parameter int ADDR_W  = DFLT_ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic [PHASE_W-1:0] inc,
  output logic [ADDR_W-1:0]  addr
);
  logic [PHASE_W-1:0] acc;

  // Natural modulo-2^PHASE_W wrap, no saturation
  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (adv) acc <= acc + inc;
  end

  assign addr = acc[PHASE_W-1 -: ADDR_W];

  a_r8_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(acc));
  a_r3_zero_step: assert property (@(posedge clk) disable iff (rst)
    (adv && inc == '0) |=> $stable(acc));
endmodule

// File: rtl/dds_sample_stage.sv
module dds_sample_stage
  import dds_pkg::*;
#(
  parameter int SAMPLE_W = DFLT_SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] rd_data,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                adv
);
  // Accept when empty or when the held sample is being taken
  assign adv = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= 1'b1;
      out_data  <= rd_data;
    end
  end

  a_r8_sample_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r7_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);
endmodule

// File: rtl/dds_wave_addr.sv
module dds_wave_addr
  import dds_pkg::*;
#(
  parameter int PHASE_W  = DFLT_PHASE_W,
  parameter int ADDR_W   = DFLT_ADDR_W,
  parameter int SAMPLE_W = DFLT_SAMPLE_W,
  parameter int SEL_W    = DFLT_SEL_W,
  parameter int REG_AW   = $clog2(PHASE_W / BYTE_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [ADDR_W-1:0]   tbl_addr,
  output logic [SEL_W-1:0]    tbl_sel,
  input  logic [SAMPLE_W-1:0] tbl_data,
  output logic                smp_valid,
  input  logic                smp_ready,
  output logic [SAMPLE_W-1:0] smp_data
);
  logic [PHASE_W-1:0] live_inc;
  logic               adv;

  dds_incr_regs #(.PHASE_W(PHASE_W), .SEL_W(SEL_W), .AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .live_inc(live_inc), .tbl_sel(tbl_sel)
  );

  dds_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst(rst), .adv(adv), .inc(live_inc), .addr(tbl_addr)
  );

  dds_sample_stage #(.SAMPLE_W(SAMPLE_W)) u_out (
    .clk(clk), .rst(rst), .rd_data(tbl_data), .out_ready(smp_ready),
    .out_valid(smp_valid), .out_data(smp_data), .adv(adv)
  );

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (tbl_addr == '0 && tbl_sel == '0 && !smp_valid));
  a_r7_first_valid: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> smp_valid);
endmodule

// File: tb/dds_wave_addr_tb.sv
module dds_wave_addr_tb;
  localparam int CLK_PERIOD = 100;
  localparam int NV = 5;
  // {sel[1:0], increment[47:0], accepted steps[15:0]}
  localparam logic [65:0] VECS [NV] = '{
    {2'd0, 48'h0008_0000_0000, 16'd5},
    {2'd1, 48'h8000_0000_0000, 16'd3},
    {2'd2, 48'hFFFF_FFFF_FFFF, 16'd2},
    {2'd3, 48'h0000_0000_0001, 16'd10},
    {2'd0, 48'h1234_5678_9ABC, 16'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic smp_ready = 1'b0;
  logic [12:0] tbl_addr;
  logic [1:0] tbl_sel;
  logic [11:0] tbl_data;
  logic smp_valid;
  logic [11:0] smp_data;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] tbl_f(input logic [1:0] s, input logic [12:0] a);
    case (s)
      2'd0: tbl_f = a[12:1];
      2'd1: tbl_f = ~a[12:1];
      2'd2: tbl_f = {a[3:0], a[12:5]};
      default: tbl_f = a[11:0] ^ 12'hA5C;
    endcase
  endfunction

  assign tbl_data = tbl_f(tbl_sel, tbl_addr);

  dds_wave_addr u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tbl_addr(tbl_addr), .tbl_sel(tbl_sel), .tbl_data(tbl_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; smp_ready = 1'b0; wr_en = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic program_inc(input logic [47:0] inc);
    for (int b = 0; b < 6; b++) wr(3'(b), inc[8*b +: 8]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [12:0] a0;
    logic [11:0] d0;
    tick();
    // R1: reset state while reset is held
    do_reset();
    chk(tbl_addr == 13'd0, "R1 addr", 64'(tbl_addr), 64'd0);
    chk(tbl_sel == 2'd0, "R1 sel", 64'(tbl_sel), 64'd0);
    chk(!smp_valid, "R1 valid", 64'(smp_valid), 64'd0);
    tick();
    // R7: valid rises without ready
    chk(smp_valid, "R7 first valid", 64'(smp_valid), 64'd1);

    // Vector walk: R2, R3, R5, R7
    for (int v = 0; v < NV; v++) begin
      logic [1:0] s;
      logic [47:0] inc, acc_n, acc_p;
      logic [15:0] n;
      {s, inc, n} = VECS[v];
      do_reset();
      program_inc(inc);
      wr(3'd6, {s, 6'b10_1101});
      smp_ready = 1'b1;
      repeat (int'(n)) tick();
      smp_ready = 1'b0;
      acc_n = 48'(inc * 48'(n));
      acc_p = 48'(inc * 48'(n - 16'd1));
      chk(tbl_addr == acc_n[47:35], "R3 addr after steps", 64'(tbl_addr), 64'(acc_n[47:35]));
      chk(tbl_sel == s, "R2 sel", 64'(tbl_sel), 64'(s));
      chk(smp_data == tbl_f(s, acc_p[47:35]), "R7 sample", 64'(smp_data), 64'(tbl_f(s, acc_p[47:35])));
    end

    // R4/R5: partial bytes do not change the step; sixth byte does
    do_reset();
    program_inc(48'h0008_0000_0000);
    smp_ready = 1'b1;
    tick();
    a0 = tbl_addr;
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd4, 8'h10);
    chk(tbl_addr == 13'(a0 + 13'd5), "R4 step unchanged", 64'(tbl_addr), 64'(13'(a0 + 13'd5)));
    wr(3'd5, 8'h00);
    chk(tbl_addr == 13'(a0 + 13'd6), "R5 commit edge uses old step", 64'(tbl_addr), 64'(13'(a0 + 13'd6)));
    tick();
    chk(tbl_addr == 13'(a0 + 13'd8), "R5 new step", 64'(tbl_addr), 64'(13'(a0 + 13'd8)));

    // R8: stall holds sample and phase
    smp_ready = 1'b0;
    tick();
    a0 = tbl_addr; d0 = smp_data;
    repeat (4) tick();
    chk(tbl_addr == a0, "R8 phase held", 64'(tbl_addr), 64'(a0));
    chk(smp_data == d0 && smp_valid, "R8 sample held", 64'(smp_data), 64'(d0));
    smp_ready = 1'b1;
    tick();
    smp_ready = 1'b0;
    chk(tbl_addr == 13'(a0 + 13'd2), "R8 resume", 64'(tbl_addr), 64'(13'(a0 + 13'd2)));
    chk(smp_data == tbl_f(tbl_sel, a0), "R7 resume sample", 64'(smp_data), 64'(tbl_f(tbl_sel, a0)));

    // R6: select from bits [7:6], low bits and address 7 ignored
    wr(3'd6, 8'hC0);
    chk(tbl_sel == 2'd3, "R6 sel 3", 64'(tbl_sel), 64'd3);
    wr(3'd6, 8'h7F);
    chk(tbl_sel == 2'd1, "R6 low bits ignored", 64'(tbl_sel), 64'd1);
    a0 = tbl_addr;
    wr(3'd7, 8'hFF);
    chk(tbl_sel == 2'd1, "R6 addr 7 sel", 64'(tbl_sel), 64'd1);
    smp_ready = 1'b1;
    tick();
    smp_ready = 1'b0;
    chk(tbl_addr == 13'(a0 + 13'd2), "R6 addr 7 step", 64'(tbl_addr), 64'(13'(a0 + 13'd2)));

    // R1: reset clears a nonzero select and phase
    do_reset();
    chk(tbl_sel == 2'd0 && tbl_addr == 13'd0, "R1 clear after use",
        64'({tbl_sel, tbl_addr}), 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule